// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block models a clocked static memory that sits on a processor cache bus. Every command is sampled on the rising clock edge: an address load starts an access at the word on the address bus, and each later advance cycle steps a two-bit burst counter. The counter drives the two lowest address bits, so one start address yields four word addresses without the processor putting new addresses on the bus. The burst order is chosen per access with an order input: linear (start plus count, wrapping inside the aligned group of four words) or interleaved (start XOR count).

The output timing is set by a build parameter. In flow-through mode a read beat shows on the output in the cycle after its command edge, so four beats fill four cycles. In pipelined mode an output register adds one cycle, so a four-beat burst spans five cycles. In pipelined mode a write command that comes right after a read beat is dropped, so the caller has to leave one idle cycle between a read and a following write. Four byte-lane write enables allow partial word writes, and a chip enable turns commands off entirely. The storage array is behavioural. The default address width of 10 keeps elaboration small; setting it to 15 gives the full 32K by 32-bit array.

Top module: `sync_burst_sram`

## Requirements
- R1: With `order_sel` = 0 (linear), the beat after one with low address bits L has low bits (L+1) mod 4. The upper address bits stay the same. Advancing more than three times wraps the two-bit counter.
- R2: With `order_sel` = 1 (interleaved), beat k of a burst (k = 0..3) uses low address bits start XOR k. Writes follow the same order.
- R3: An address load with `chip_en` high restarts the burst at the bus address, even in the middle of a burst.
- R4: With PIPELINED = 0, a read beat whose command is sampled at edge n sets `rvalid` and shows its word on `rdata` in the cycle after edge n.
- R5: With PIPELINED = 1, the same read beat appears one cycle later, after edge n+1.
- R6: On a write, `byte_wen[i]` = 1 stores `wdata[8i+7:8i]` into that lane. Lanes whose enable is 0 keep their old contents.
- R7: While `chip_en` is low, no write takes place, no read beat is produced, and advance does not move the counter.
- R8: With PIPELINED = 1, a write load in the cycle right after a read beat is ignored. With PIPELINED = 0 the same write is performed.
- R9: After reset, `rvalid` is low until a read is issued.
- R10: A word written at an address is returned unchanged by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| chip_en | input | 1 | Device select; low means the cycle's command is ignored |
| adr_load | input | 1 | Start an access at `addr` |
| burst_adv | input | 1 | Step to the next burst beat (when `adr_load` is low) |
| wr_req | input | 1 | With `adr_load`: 1 = write burst, 0 = read burst |
| order_sel | input | 1 | Burst order for the new access: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Start word address |
| byte_wen | input | DATA_W/8 | Per-lane write enables, bit i for bits 8i+7..8i |
| wdata | input | DATA_W | Write data for the current beat |
| rdata | output | DATA_W | Read data, zero when `rvalid` is low |
| rvalid | output | 1 | High in each cycle that carries a read beat |

## Verification
Both output modes run side by side on the same stimulus, each against its own behavioural model that is checked every cycle. This means a latency error shows up as a mismatch in one mode only. Linear and interleaved bursts start from every low-bit offset of interest, and a six-beat run checks the counter wrap. Because the preloaded words are all distinct, a wrong beat order gives a wrong data word, not just a wrong address. Further patterns cover a reload in mid-burst, deselect cycles inside a burst, partial-lane writes over known words, and a write issued right after a read, which is the one stimulus where the two modes must disagree.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // width of one byte-enable lane
    localparam int LANE_W = 8;

    // low two address bits of a burst beat from the start bits and beat index
    function automatic logic [1:0] beat_low(
        input logic [1:0] start,
        input logic [1:0] idx,
        input logic       ilv
    );
        return ilv ? (start ^ idx) : (start + idx);
    endfunction

endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PIPELINED = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              strobe,
    input  logic              advance,
    input  logic              write_en,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_beat,
    output logic [ADDR_W-1:0] rd_addr
);

    typedef struct packed {
        logic              live;
        logic              wr_op;
        logic              ilv;
        logic              rd_beat;
        logic [1:0]        cnt;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
    } seq_t;

    seq_t       q, d;
    logic       accept;
    logic       step;
    logic       turn_block;
    logic [1:0] nxt_cnt;

    always_comb begin
        d          = q;
        d.rd_beat  = 1'b0;
        wr_fire    = 1'b0;
        wr_addr    = addr_in;
        nxt_cnt    = q.cnt + 2'd1;
        turn_block = (PIPELINED != 0) && q.rd_beat && write_en;
        accept     = chip_en && strobe && !turn_block;
        step       = chip_en && !strobe && advance && q.live;
        if (accept) begin
            d.live    = 1'b1;
            d.wr_op   = write_en;
            d.ilv     = order_sel;
            d.cnt     = 2'd0;
            d.base    = addr_in;
            d.cur     = addr_in;
            d.rd_beat = !write_en;
            wr_fire   = write_en;
            wr_addr   = addr_in;
        end else if (step) begin
            d.cnt     = nxt_cnt;
            d.cur     = {q.base[ADDR_W-1:2], beat_low(q.base[1:0], nxt_cnt, q.ilv)};
            d.rd_beat = !q.wr_op;
            wr_fire   = q.wr_op;
            wr_addr   = d.cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_beat = q.rd_beat;
    assign rd_addr = q.cur;

    // R3: a read load restarts the burst at the bus address
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && strobe && !write_en) |=>
            (q.cnt == 2'd0 && q.cur == $past(addr_in) && q.rd_beat));

    // R1: linear steps add one to the low bits, upper bits fixed
    a_r1_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !q.ilv) |=>
            (q.cur[1:0] == $past(q.cur[1:0]) + 2'd1 &&
             q.cur[ADDR_W-1:2] == $past(q.cur[ADDR_W-1:2])));

    // R2: interleaved beats are start XOR count
    a_r2_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && q.ilv) |=>
            ((q.cur[1:0] ^ q.base[1:0]) == q.cnt && $stable(q.base)));

    // R7: a deselected cycle yields no read beat
    a_r7_no_beat_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !q.rd_beat);

    // R7: a deselected cycle leaves the counter alone
    a_r7_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> $stable(q.cnt));

endmodule

// File: rtl/sbs_store.sv
module sbs_store
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [DATA_W/LANE_W-1:0] be,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = DATA_W / LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < NB; i++) begin
                if (be[i]) begin
                    mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int PIPELINED = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chip_en,
    input  logic                     adr_load,
    input  logic                     burst_adv,
    input  logic                     wr_req,
    input  logic                     order_sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W/LANE_W-1:0] byte_wen,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid
);

    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic              rd_beat;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] arr_rdata;

    sbs_burst_seq #(
        .ADDR_W    (ADDR_W),
        .PIPELINED (PIPELINED)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en   (chip_en),
        .strobe    (adr_load),
        .advance   (burst_adv),
        .write_en  (wr_req),
        .order_sel (order_sel),
        .addr_in   (addr),
        .wr_fire   (arr_we),
        .wr_addr   (arr_waddr),
        .rd_beat   (rd_beat),
        .rd_addr   (rd_addr)
    );

    sbs_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (arr_we),
        .be    (byte_wen),
        .waddr (arr_waddr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    generate
        if (PIPELINED != 0) begin : g_pipe
            typedef struct packed {
                logic              vld;
                logic [DATA_W-1:0] dat;
            } out_t;

            out_t oq, od;

            always_comb begin
                od.vld = rd_beat;
                od.dat = rd_beat ? arr_rdata : '0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    oq <= '0;
                end else begin
                    oq <= od;
                end
            end

            assign rvalid = oq.vld;
            assign rdata  = oq.dat;

            // R5: a read beat reaches the pins one cycle after the array
            a_r5_one_cycle_late: assert property (@(posedge clk) disable iff (!rst_n)
                rd_beat |=> (rvalid && rdata == $past(arr_rdata)));

            // R5: no output beat without an array beat the cycle before
            a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_beat |=> !rvalid);
        end else begin : g_flow
            assign rvalid = rd_beat;
            assign rdata  = rd_beat ? arr_rdata : '0;
        end
    endgenerate

    // R8: pipelined mode drops a write load right after a read beat
    a_r8_turnaround_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((PIPELINED != 0) && rd_beat && chip_en && adr_load && wr_req) |-> !arr_we);

    // R8: flow-through mode accepts every selected write load
    a_r8_flow_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        ((PIPELINED == 0) && chip_en && adr_load && wr_req) |-> arr_we);

    // R7: no array write while deselected
    a_r7_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> !arr_we);

    // R9: quiet output straight after a reset cycle
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !rvalid);

endmodule

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0, ld = 1'b0, adv = 1'b0, we = 1'b0, ord = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wd = '0;
    logic [31:0]   rd0, rd1;
    logic          rv0, rv1;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(32), .PIPELINED(0)) u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .chip_en(ce), .adr_load(ld), .burst_adv(adv),
        .wr_req(we), .order_sel(ord), .addr(addr), .byte_wen(be), .wdata(wd),
        .rdata(rd0), .rvalid(rv0));

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(32), .PIPELINED(1)) u_sync_burst_sram_p (
        .clk(clk), .rst_n(rst_n), .chip_en(ce), .adr_load(ld), .burst_adv(adv),
        .wr_req(we), .order_sel(ord), .addr(addr), .byte_wen(be), .wdata(wd),
        .rdata(rd1), .rvalid(rv1));

    // behavioural reference, index 0 flow-through, 1 pipelined
    logic [31:0] ref_mem [2][DEPTH];
    bit          live [2];
    bit          wrop [2];
    bit          ilvm [2];
    bit          rdb  [2];
    int          base [2];
    int          cnt  [2];
    bit          exp_v [2][4];
    logic [31:0] exp_d [2][4];

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    wd_ctr = 0;
    bit    done = 1'b0;
    string cur_req = "R9";

    function automatic logic [31:0] next_wd();
        wd_ctr++;
        return (wd_ctr * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic mwrite(input int m, input int a, input logic [3:0] b, input logic [31:0] d);
        for (int i = 0; i < 4; i++) begin
            if (b[i]) ref_mem[m][a][i*8 +: 8] = d[i*8 +: 8];
        end
    endtask

    task automatic model_step(input int m, input int n, input bit c, input bit l,
                              input bit a_, input bit w, input bit o, input int ad,
                              input logic [3:0] b, input logic [31:0] d);
        bit acc, stp, rd;
        int beat, lo, slot;
        acc  = c && l && !(w && m == 1 && rdb[m]);
        stp  = c && !l && a_ && live[m];
        rd   = 1'b0;
        beat = 0;
        if (acc) begin
            live[m] = 1'b1; wrop[m] = w; ilvm[m] = o; cnt[m] = 0; base[m] = ad;
            beat = ad;
            rd = !w;
            if (w) mwrite(m, beat, b, d);
        end else if (stp) begin
            cnt[m] = (cnt[m] + 1) % 4;
            lo = ilvm[m] ? ((base[m] % 4) ^ cnt[m]) : ((base[m] % 4 + cnt[m]) % 4);
            beat = base[m] - (base[m] % 4) + lo;
            rd = !wrop[m];
            if (wrop[m]) mwrite(m, beat, b, d);
        end
        rdb[m] = rd;
        if (rd) begin
            slot = (n + m) % 4;
            exp_v[m][slot] = 1'b1;
            exp_d[m][slot] = ref_mem[m][beat];
        end
    endtask

    task automatic check_mode(input int m);
        int          s;
        logic        gv;
        logic [31:0] gd;
        s  = cyc % 4;
        gv = (m == 0) ? rv0 : rv1;
        gd = (m == 0) ? rd0 : rd1;
        checks++;
        if (gv !== exp_v[m][s]) begin
            errors++;
            $display("FAIL %s mode=%0d cycle=%0d rvalid got %0b expected %0b",
                     cur_req, m, cyc, gv, exp_v[m][s]);
        end else if (exp_v[m][s] && gd !== exp_d[m][s]) begin
            errors++;
            $display("FAIL %s mode=%0d cycle=%0d rdata got %h expected %h",
                     cur_req, m, cyc, gd, exp_d[m][s]);
        end
        exp_v[m][s] = 1'b0;
    endtask

    task automatic cmd(input bit c, input bit l, input bit a_, input bit w, input bit o,
                       input int ad, input logic [3:0] b, input logic [31:0] d);
        int n;
        n = cyc + 1;
        for (int m = 0; m < 2; m++) model_step(m, n, c, l, a_, w, o, ad, b, d);
        ce = c; ld = l; adv = a_; we = w; ord = o;
        addr = AW'(ad); be = b; wd = d;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        for (int m = 0; m < 2; m++) check_mode(m);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cmd(0, 0, 0, 0, 0, 0, 4'h0, 32'h0);
    endtask

    task automatic wr_burst(input int a, input bit o, input logic [3:0] b);
        cmd(1, 1, 0, 1, o, a, b, next_wd());
        for (int i = 0; i < 3; i++) cmd(1, 0, 1, 0, o, 0, b, next_wd());
    endtask

    task automatic rd_burst(input int a, input bit o, input int beats);
        cmd(1, 1, 0, 0, o, a, 4'h0, 32'h0);
        for (int i = 1; i < beats; i++) cmd(1, 0, 1, 0, o, 0, 4'h0, 32'h0);
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            live[m] = 0; wrop[m] = 0; ilvm[m] = 0; rdb[m] = 0; base[m] = 0; cnt[m] = 0;
            for (int s = 0; s < 4; s++) begin
                exp_v[m][s] = 1'b0;
                exp_d[m][s] = '0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: outputs quiet out of reset
        cur_req = "R9";
        checks++;
        if (rv0 !== 1'b0 || rv1 !== 1'b0) begin
            errors++;
            $display("FAIL R9 rvalid got %0b/%0b expected 0/0", rv0, rv1);
        end
        idle(3);

        // R10: fill words 0..63, then read some back
        cur_req = "R10";
        for (int b = 0; b < 16; b++) wr_burst(b * 4, 1'b0, 4'hF);
        rd_burst(0, 1'b0, 4);
        rd_burst(60, 1'b0, 4);
        idle(2);

        // R1: linear order from offset 2 and a wrapping six-beat run
        cur_req = "R1";
        rd_burst(6, 1'b0, 4);
        rd_burst(13, 1'b0, 6);
        idle(2);

        // R2: interleaved order from offsets 1 and 2, plus an interleaved write
        cur_req = "R2";
        rd_burst(9, 1'b1, 4);
        rd_burst(14, 1'b1, 4);
        idle(2);
        wr_burst(66, 1'b1, 4'hF);
        idle(1);
        rd_burst(64, 1'b0, 4);
        idle(2);

        // R3: reload in mid-burst
        cur_req = "R3";
        rd_burst(20, 1'b0, 2);
        rd_burst(33, 1'b0, 4);
        idle(2);

        // R4 R5: an isolated single beat shows the latency of each mode
        cur_req = "R4 R5";
        rd_burst(3, 1'b0, 1);
        idle(3);

        // R6: partial-lane writes over known words
        cur_req = "R6";
        wr_burst(40, 1'b0, 4'b0101);
        idle(1);
        cmd(1, 1, 0, 1, 0, 45, 4'b0000, next_wd());
        cmd(1, 1, 0, 1, 0, 46, 4'b1000, next_wd());
        idle(1);
        rd_burst(40, 1'b0, 4);
        rd_burst(44, 1'b0, 4);
        idle(2);

        // R7: deselect inside a burst, deselected write and read
        cur_req = "R7";
        rd_burst(24, 1'b0, 1);
        cmd(0, 0, 1, 0, 0, 0, 4'h0, 32'h0);
        cmd(0, 1, 0, 1, 0, 25, 4'hF, next_wd());
        cmd(0, 1, 0, 0, 0, 30, 4'h0, 32'h0);
        cmd(1, 0, 1, 0, 0, 0, 4'h0, 32'h0);
        cmd(1, 0, 1, 0, 0, 0, 4'h0, 32'h0);
        cmd(1, 0, 1, 0, 0, 0, 4'h0, 32'h0);
        idle(2);

        // R8: write directly after a read, then with one idle cycle between
        cur_req = "R8";
        rd_burst(50, 1'b0, 1);
        cmd(1, 1, 0, 1, 0, 50, 4'hF, next_wd());
        idle(2);
        rd_burst(50, 1'b0, 1);
        idle(2);
        rd_burst(52, 1'b0, 1);
        idle(1);
        cmd(1, 1, 0, 1, 0, 52, 4'hF, next_wd());
        idle(2);
        rd_burst(52, 1'b0, 1);
        idle(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule